// File: doc/BRIEF.md
# Receive Transaction Counter

This block sits beside the DMA-side read port of a buffered endpoint pipe whose data flows out of the buffer toward the host side. Software programs a target number of packet transactions. Each receive transaction that completes while counting is switched on advances an internal live count. The buffer is released for reading once the live count reaches the target. A target of zero leaves the read gate open at all times.

A single register read port returns either the programmed target or the live count. The choice follows the counting-enable input. Two interlocks protect a transfer in progress. A clear command is refused while counting is on and the pipe handshake is in its buffer-ready state, and also while any data is left in the buffer. A request to select another pipe is refused while the live count is not zero. Every refusal leaves the state as it was and raises a sticky reject flag, which only reset lowers.

Top module: `rx_txn_counter`

## Requirements
- R1: After synchronous reset, rd_data is 0, rd_ok is 1, reject is 0 and cur_pipe is 0.
- R2: A pulse on tgt_we stores tgt_wdata as the target. With cnt_en at 0, rd_data shows the target from the next clock edge onward.
- R3: With cnt_en at 1, rd_data shows the live count. Each txn_done pulse raises the count by one. A txn_done pulse while cnt_en is 0 leaves the count unchanged.
- R4: rd_ok is 1 exactly when the live count is greater than or equal to the target, so a target of 0 keeps rd_ok at 1.
- R5: The live count never exceeds the target. A txn_done at the target is ignored, with no wrap.
- R6: An accepted clr_req sets the live count to 0.
- R7: A clr_req while cnt_en and hs_buf are both 1 is refused: the count is kept and reject goes to 1. With cnt_en at 0, hs_buf alone does not block a clear.
- R8: A clr_req while buf_nz is 1 is refused: the count is kept and reject goes to 1.
- R9: A sel_req while the live count is not 0 leaves cur_pipe unchanged and sets reject. A sel_req with a count of 0 loads sel_pipe into cur_pipe.
- R10: Once set, reject stays at 1 until reset, including through later accepted commands.
- R11: Writing a target below the live count pulls the count down to the new target. Writing a larger target keeps the count.
- R12: When an accepted clr_req and a txn_done arrive in the same cycle, the clear wins and the count becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tgt_we | input | 1 | Target write strobe |
| tgt_wdata | input | 16 | Target value to store |
| cnt_en | input | 1 | Counting enable; also selects what rd_data shows (0 target, 1 live count) |
| txn_done | input | 1 | One-cycle pulse per completed receive transaction |
| clr_req | input | 1 | Clear command for the live count |
| hs_buf | input | 1 | Pipe handshake is in the buffer-ready state |
| buf_nz | input | 1 | Buffer still holds data |
| sel_req | input | 1 | Pipe reselection request |
| sel_pipe | input | 3 | Pipe number requested |
| rd_data | output | 16 | Readback value, target or live count |
| rd_ok | output | 1 | Buffer read enable |
| reject | output | 1 | Sticky flag, set by a refused clear or pipe change |
| cur_pipe | output | 3 | Currently selected pipe |

## Verification
Every output is registered from next-state logic. A stimulus held during one cycle therefore shows on rd_data, rd_ok, reject and cur_pipe at the first rising edge after it, with no further delay. The exception is a change on cnt_en alone, which switches the readback source at that same next edge. The bench drives inputs on the falling edge and samples one time unit after the following rising edge, so each check lands in the first cycle the result is due. Refusals are checked by reading the count back through rd_data, and pipe holds through cur_pipe, in the cycle right after the refused command.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  typedef struct packed {
    logic clr_ok;
    logic sel_ok;
    logic rej_set;
  } rtc_dec_t;
endpackage

// File: rtl/rtc_guard.sv
module rtc_guard
  import rtc_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cnt_en,
  input  logic          hs_buf,
  input  logic          buf_nz,
  input  logic          clr_req,
  input  logic          sel_req,
  input  logic [CW-1:0] cnt_q,
  output rtc_dec_t      dec,
  output logic          reject_q
);
  logic clr_block;
  logic sel_block;

  always_comb begin
    clr_block   = (cnt_en & hs_buf) | buf_nz;
    sel_block   = (cnt_q != '0);
    dec.clr_ok  = clr_req & ~clr_block;
    dec.sel_ok  = sel_req & ~sel_block;
    dec.rej_set = (clr_req & clr_block) | (sel_req & sel_block);
  end

  always_ff @(posedge clk) begin
    if (rst)              reject_q <= 1'b0;
    else if (dec.rej_set) reject_q <= 1'b1;
  end

  AST_REJ_STICKY: assert property (@(posedge clk) disable iff (rst)
    reject_q |=> reject_q); // R10
endmodule

// File: rtl/rtc_count.sv
module rtc_count #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tgt_we,
  input  logic [CW-1:0] tgt_wdata,
  input  logic          cnt_en,
  input  logic          txn_done,
  input  logic          clr_ok,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] tgt_d,
  output logic [CW-1:0] cnt_d
);
  logic [CW-1:0] tgt_q;
  logic [CW-1:0] stepped;
  logic          can_step;

  always_comb begin
    tgt_d    = tgt_we ? tgt_wdata : tgt_q;
    can_step = cnt_en & txn_done & (cnt_q < tgt_q);
    stepped  = can_step ? cnt_q + 1'b1 : cnt_q;
    if (clr_ok)              cnt_d = '0;
    else if (stepped > tgt_d) cnt_d = tgt_d;
    else                     cnt_d = stepped;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_q <= '0;
      cnt_q <= '0;
    end else begin
      tgt_q <= tgt_d;
      cnt_q <= cnt_d;
    end
  end

  AST_CNT_LE_TGT: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= tgt_q); // R5
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (rst)
    clr_ok |=> (cnt_q == '0)); // R6
  AST_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ({1'b0, cnt_q} <= ({1'b0, $past(cnt_q)} + 1'b1))); // R3
endmodule

// File: rtl/rtc_pipe.sv
module rtc_pipe #(
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel_ok,
  input  logic [PW-1:0] sel_pipe,
  output logic [PW-1:0] cur_pipe_q
);
  always_ff @(posedge clk) begin
    if (rst)         cur_pipe_q <= '0;
    else if (sel_ok) cur_pipe_q <= sel_pipe;
  end
endmodule

// File: rtl/rtc_out.sv
module rtc_out #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cnt_en,
  input  logic [CW-1:0] tgt_d,
  input  logic [CW-1:0] cnt_d,
  output logic [CW-1:0] rd_data_q,
  output logic          rd_ok_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data_q <= '0;
      rd_ok_q   <= 1'b1;
    end else begin
      rd_data_q <= cnt_en ? cnt_d : tgt_d;
      rd_ok_q   <= (cnt_d >= tgt_d);
    end
  end
endmodule

// File: rtl/rx_txn_counter.sv
module rx_txn_counter
  import rtc_pkg::*;
#(
  parameter int CW = 16,
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tgt_we,
  input  logic [CW-1:0] tgt_wdata,
  input  logic          cnt_en,
  input  logic          txn_done,
  input  logic          clr_req,
  input  logic          hs_buf,
  input  logic          buf_nz,
  input  logic          sel_req,
  input  logic [PW-1:0] sel_pipe,
  output logic [CW-1:0] rd_data,
  output logic          rd_ok,
  output logic          reject,
  output logic [PW-1:0] cur_pipe
);
  rtc_dec_t      dec;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] tgt_d;
  logic [CW-1:0] cnt_d;

  rtc_guard #(.CW(CW)) u_guard (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .hs_buf(hs_buf), .buf_nz(buf_nz),
    .clr_req(clr_req), .sel_req(sel_req), .cnt_q(cnt_q), .dec(dec),
    .reject_q(reject)
  );

  rtc_count #(.CW(CW)) u_count (
    .clk(clk), .rst(rst), .tgt_we(tgt_we), .tgt_wdata(tgt_wdata),
    .cnt_en(cnt_en), .txn_done(txn_done), .clr_ok(dec.clr_ok),
    .cnt_q(cnt_q), .tgt_d(tgt_d), .cnt_d(cnt_d)
  );

  rtc_pipe #(.PW(PW)) u_pipe (
    .clk(clk), .rst(rst), .sel_ok(dec.sel_ok), .sel_pipe(sel_pipe),
    .cur_pipe_q(cur_pipe)
  );

  rtc_out #(.CW(CW)) u_out (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .tgt_d(tgt_d), .cnt_d(cnt_d),
    .rd_data_q(rd_data), .rd_ok_q(rd_ok)
  );

  AST_CLR_BUF_REFUSE: assert property (@(posedge clk) disable iff (rst)
    (clr_req && buf_nz) |=> reject); // R8
  AST_CLR_HS_REFUSE: assert property (@(posedge clk) disable iff (rst)
    (clr_req && cnt_en && hs_buf) |=> reject); // R7
  AST_PIPE_LOCK: assert property (@(posedge clk) disable iff (rst)
    (sel_req && (cnt_q != '0)) |=> ($stable(cur_pipe) && reject)); // R9
endmodule

// File: tb/rx_txn_counter_tb.sv
`timescale 1ns/1ps
module rx_txn_counter_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tgt_we = 0, cnt_en = 0, txn_done = 0, clr_req = 0;
  logic        hs_buf = 0, buf_nz = 0, sel_req = 0;
  logic [15:0] tgt_wdata = '0;
  logic [2:0]  sel_pipe = '0;
  logic [15:0] rd_data;
  logic        rd_ok, reject;
  logic [2:0]  cur_pipe;
  int          n_run = 0, n_fail = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  rx_txn_counter u_dut (
    .clk(clk), .rst(rst), .tgt_we(tgt_we), .tgt_wdata(tgt_wdata),
    .cnt_en(cnt_en), .txn_done(txn_done), .clr_req(clr_req), .hs_buf(hs_buf),
    .buf_nz(buf_nz), .sel_req(sel_req), .sel_pipe(sel_pipe),
    .rd_data(rd_data), .rd_ok(rd_ok), .reject(reject), .cur_pipe(cur_pipe)
  );

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Advance one cycle: pulses set before the call last exactly this cycle.
  task automatic tick();
    @(posedge clk); #1;
    tgt_we = 0; txn_done = 0; clr_req = 0; sel_req = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; cnt_en = 0; hs_buf = 0; buf_nz = 0;
    tick(); tick();
    @(negedge clk); rst = 0;
  endtask

  task automatic wr_tgt(int v);
    @(negedge clk); tgt_we = 1; tgt_wdata = v[15:0]; tick();
  endtask

  task automatic pulse_txn(int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk); txn_done = 1; tick();
    end
  endtask

  task automatic set_en(bit v);
    @(negedge clk); cnt_en = v; tick();
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 rd_data", rd_data, 0);
    chk("R1 rd_ok", rd_ok, 1);
    chk("R1 reject", reject, 0);
    chk("R1 cur_pipe", cur_pipe, 0);
  endtask

  task automatic t_count();
    do_reset();
    wr_tgt(3);
    chk("R2 target readback", rd_data, 3);
    chk("R4 gate closed", rd_ok, 0);
    set_en(1);
    chk("R3 live count zero", rd_data, 0);
    pulse_txn(1);
    chk("R3 count 1", rd_data, 1);
    @(negedge clk); cnt_en = 0; txn_done = 1; tick();
    chk("R2 target when disabled", rd_data, 3);
    set_en(1);
    chk("R3 txn ignored when disabled", rd_data, 1);
    pulse_txn(2);
    chk("R3 count 3", rd_data, 3);
    chk("R4 gate open", rd_ok, 1);
    pulse_txn(1);
    chk("R5 saturate", rd_data, 3);
  endtask

  task automatic t_clr_hs();
    do_reset();
    wr_tgt(2); set_en(1); pulse_txn(2);
    @(negedge clk); hs_buf = 1; clr_req = 1; tick();
    chk("R7 count kept", rd_data, 2);
    chk("R7 reject", reject, 1);
    @(negedge clk); cnt_en = 0; clr_req = 1; tick();
    set_en(1);
    chk("R7 clear ok with counting off", rd_data, 0);
    chk("R4 gate closed after clear", rd_ok, 0);
    hs_buf = 0;
  endtask

  task automatic t_clr_buf();
    do_reset();
    wr_tgt(2); set_en(1); pulse_txn(1);
    @(negedge clk); buf_nz = 1; clr_req = 1; tick();
    chk("R8 count kept", rd_data, 1);
    chk("R8 reject", reject, 1);
    @(negedge clk); buf_nz = 0; clr_req = 1; tick();
    chk("R6 cleared", rd_data, 0);
    chk("R10 reject sticky", reject, 1);
  endtask

  task automatic t_pipe();
    do_reset();
    wr_tgt(4); set_en(1);
    @(negedge clk); sel_req = 1; sel_pipe = 3'd5; tick();
    chk("R9 select at zero", cur_pipe, 5);
    chk("R9 no reject", reject, 0);
    pulse_txn(1);
    @(negedge clk); sel_req = 1; sel_pipe = 3'd2; tick();
    chk("R9 pipe held", cur_pipe, 5);
    chk("R9 reject", reject, 1);
    chk("R9 count kept", rd_data, 1);
    @(negedge clk); clr_req = 1; tick();
    @(negedge clk); sel_req = 1; sel_pipe = 3'd2; tick();
    chk("R9 select after clear", cur_pipe, 2);
  endtask

  task automatic t_clamp();
    do_reset();
    wr_tgt(5); set_en(1); pulse_txn(4);
    chk("R3 count 4", rd_data, 4);
    wr_tgt(2);
    chk("R11 clamped", rd_data, 2);
    chk("R11 gate open", rd_ok, 1);
    wr_tgt(6);
    chk("R11 kept on raise", rd_data, 2);
    chk("R11 gate closed", rd_ok, 0);
  endtask

  task automatic t_clr_win();
    do_reset();
    wr_tgt(3); set_en(1); pulse_txn(1);
    @(negedge clk); clr_req = 1; txn_done = 1; tick();
    chk("R12 clear wins", rd_data, 0);
  endtask

  task automatic t_tgt0();
    do_reset();
    set_en(1); pulse_txn(2);
    chk("R5 zero target holds", rd_data, 0);
    chk("R4 zero target gate", rd_ok, 1);
  endtask

  initial begin
    t_reset();
    t_count();
    t_clr_hs();
    t_clr_buf();
    t_pipe();
    t_clamp();
    t_clr_win();
    t_tgt0();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule